// File: doc/BRIEF.md
# Timeslot to Logical Channel Router

The router sits between a frame decoder and a bank of per-channel buffers. It accepts the decoded bytes of each frame as a stream. Each beat carries the byte's slot index and a flag that marks the first byte of a frame. It steers each byte to one of sixteen logical channels. Each frame has 60 data slots shared between a synchronous area and an asynchronous area, followed by two control slots. A boundary value counted in 4-byte units divides the data slots. The synchronous area runs from slot 0 up to four times the boundary. A slot in that area is looked up in a programmable routing table, which decides whether the byte is kept and which channel receives it. Bytes in the asynchronous area all go to channel 0. Channel 0 never takes a synchronous slot. Control slots are dropped.

For each channel the router collects routed bytes into 32-bit words, filling the lowest byte lane first. It emits a word-write beat with a channel tag as soon as four bytes have collected. When the first byte of a new frame is presented, every channel holding a partial word is flushed first, one beat per cycle from the lowest channel number upward. Each flushed beat carries per-lane valid flags, so every frame starts with empty accumulators. A host writes the routing table one 32-bit word at a time. Each table word covers four consecutive slots.

Both streams use valid/ready. An input byte is taken on a cycle where `in_valid` and `in_ready` are both high. An output word is taken on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output beat holds steady and no input byte is taken. `in_ready` depends combinationally on `out_ready` and on `in_sof`.

Top module: `slot_router`

## Requirements
- R1: After reset the routing table is all zero, the boundary is 0, `out_valid` is low and `in_ready` is high.
- R2: A synchronous slot n reads byte lane n mod 4 (bits 8·(n mod 4)+7 down to 8·(n mod 4)) of table word n/4. When bit 7 of that lane is 1 and bits 3:0 are non-zero, the byte goes to the channel given by bits 3:0.
- R3: A synchronous slot whose lane has bit 7 clear, or whose channel field is 0, is discarded. It produces no byte on any channel.
- R4: Slots from 4·boundary up to 59 are asynchronous and go to channel 0. Slots 60 and 61 are dropped.
- R5: Bytes of a channel are packed with the first byte in bits 7:0. On the fourth byte a beat is emitted with that channel's number and byte valid flags 4'b1111.
- R6: While a frame-start byte is presented and any channel holds a partial word, `in_ready` is low. Partial words are emitted one per cycle, lowest channel first. The valid flags are 4'b0001, 4'b0011 or 4'b0111, and the unused lanes are zero. The frame-start byte is taken only after the last flush beat.
- R7: The boundary is sampled from `in_bnd` only when a frame-start byte is taken, and that frame-start byte already uses the new value. Changes to `in_bnd` during the frame take effect at the next frame start.
- R8: A table write with `tbl_addr` below 15 replaces that word. A byte taken in the same cycle as the write still uses the old word, and bytes taken afterwards use the new word.
- R9: While `out_valid` is high and `out_ready` is low, the output beat stays stable and `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Router can take the input byte |
| in_sof | input | 1 | Byte is the first of a new frame |
| in_slot | input | 6 | Slot index of the byte (0 to 61) |
| in_data | input | 8 | Byte value |
| in_bnd | input | 4 | Synchronous boundary in 4-byte units |
| tbl_we | input | 1 | Routing table write strobe |
| tbl_addr | input | 4 | Routing table word index |
| tbl_wdata | input | 32 | Routing table word value |
| out_valid | output | 1 | Word-write beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_chan | output | 4 | Logical channel of the beat |
| out_data | output | 32 | Packed word, first byte in bits 7:0 |
| out_bmask | output | 4 | Per-lane byte valid flags |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a host table write and the lookup of that same table word by an accepted byte. The bench provokes this by holding the table write until the cycle in which the byte is accepted. It then judges which channel received that byte and the bytes that follow. The second pair is a frame-start flush and output back-pressure. The bench throttles `out_ready` in a fixed rhythm across whole frames. Each beat is compared in order against a behavioural model, and any beat held under a stall must stay unchanged.

// File: rtl/slot_router_pkg.sv
package slot_router_pkg;
  // One table lane: keep flag, three spare bits, channel number.
  typedef struct packed {
    logic       keep;
    logic [2:0] spare;
    logic [3:0] chan;
  } lane_t;

  localparam int LANE_BITS  = 8;
  localparam int WORD_LANES = 4;
  localparam int WORD_BITS  = LANE_BITS * WORD_LANES;

  function automatic logic [WORD_LANES-1:0] lanes_mask(input logic [1:0] cnt);
    case (cnt)
      2'd1:    return 4'b0001;
      2'd2:    return 4'b0011;
      2'd3:    return 4'b0111;
      default: return 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/route_table.sv
module route_table #(
  parameter int N_ENTRIES = 15,
  parameter int ADDR_W    = 4,
  parameter int SLOT_W    = 6,
  parameter int CH_W      = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [ADDR_W-1:0]                   waddr,
  input  logic [slot_router_pkg::WORD_BITS-1:0] wdata,
  input  logic [SLOT_W-1:0]                   lk_slot,
  output logic                                lk_keep,
  output logic [CH_W-1:0]                     lk_chan
);
  import slot_router_pkg::*;

  localparam int IDX_W = SLOT_W - 2;

  logic [WORD_BITS-1:0] mem_q [N_ENTRIES];
  logic [WORD_BITS-1:0] sel_word;
  logic [IDX_W-1:0]     lk_idx;
  logic [1:0]           lk_lane;

  assign lk_idx  = lk_slot[SLOT_W-1:2];
  assign lk_lane = lk_slot[1:0];

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem_q[e] <= '0;
      else if (we && (waddr == ADDR_W'(e)))
        mem_q[e] <= wdata;
    end
  end

  always_comb begin
    sel_word = '0;
    for (int e = 0; e < N_ENTRIES; e++)
      if (lk_idx == IDX_W'(e)) sel_word = mem_q[e];
  end

  assign lk_keep = sel_word[{lk_lane, 3'b111}];
  assign lk_chan = sel_word[{lk_lane, 3'b000} +: CH_W];
endmodule

// File: rtl/slot_class.sv
module slot_class #(
  parameter int N_SLOTS = 60,
  parameter int SLOT_W  = 6,
  parameter int BND_W   = 4,
  parameter int CH_W    = 4
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [BND_W-1:0]  bnd,
  input  logic              tbl_keep,
  input  logic [CH_W-1:0]   tbl_chan,
  output logic              route_ok,
  output logic [CH_W-1:0]   route_ch
);
  logic is_data;
  logic is_sync;

  assign is_data = slot < SLOT_W'(N_SLOTS);
  assign is_sync = slot < {bnd, 2'b00};

  always_comb begin
    route_ok = 1'b0;
    route_ch = '0;
    if (is_data) begin
      if (is_sync) begin
        route_ok = tbl_keep && (tbl_chan != '0);
        route_ch = tbl_chan;
      end else begin
        route_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chan_packer.sv
module chan_packer #(
  parameter int N_CHAN = 16,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_we,
  input  logic [CH_W-1:0]   byte_ch,
  input  logic [7:0]        byte_data,
  input  logic              flush_take,
  output logic              word_done,
  output logic [31:0]       word_data,
  output logic [N_CHAN-1:0] pend,
  output logic [CH_W-1:0]   flush_ch,
  output logic [31:0]       flush_data,
  output logic [3:0]        flush_mask
);
  import slot_router_pkg::*;

  logic [N_CHAN-1:0][1:0]  cnt_all;
  logic [N_CHAN-1:0][23:0] acc_all;

  for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
    logic [1:0]  cnt_q;
    logic [23:0] acc_q;
    logic        hit;
    logic        drop;

    assign hit  = byte_we && (byte_ch == CH_W'(c));
    assign drop = flush_take && (flush_ch == CH_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (hit) begin
        case (cnt_q)
          2'd0: acc_q[7:0]   <= byte_data;
          2'd1: acc_q[15:8]  <= byte_data;
          2'd2: acc_q[23:16] <= byte_data;
          default: acc_q     <= '0;
        endcase
        cnt_q <= cnt_q + 2'd1;
      end else if (drop) begin
        cnt_q <= '0;
        acc_q <= '0;
      end
    end

    assign cnt_all[c] = cnt_q;
    assign acc_all[c] = acc_q;
    assign pend[c]    = cnt_q != 2'd0;
  end

  assign word_done = byte_we && (cnt_all[byte_ch] == 2'd3);
  assign word_data = {byte_data, acc_all[byte_ch]};

  always_comb begin
    flush_ch = '0;
    for (int i = N_CHAN - 1; i >= 0; i--)
      if (pend[i]) flush_ch = CH_W'(i);
  end

  assign flush_data = {8'h00, acc_all[flush_ch]};
  assign flush_mask = lanes_mask(cnt_all[flush_ch]);
endmodule

// File: rtl/slot_router.sv
module slot_router #(
  parameter int N_CHAN  = 16,
  parameter int N_SLOTS = 60,
  parameter int N_CTRL  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_sof,
  input  logic [5:0]  in_slot,
  input  logic [7:0]  in_data,
  input  logic [3:0]  in_bnd,
  input  logic        tbl_we,
  input  logic [3:0]  tbl_addr,
  input  logic [31:0] tbl_wdata,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [3:0]  out_chan,
  output logic [31:0] out_data,
  output logic [3:0]  out_bmask
);
  localparam int CH_W      = $clog2(N_CHAN);
  localparam int SLOT_W    = $clog2(N_SLOTS + N_CTRL);
  localparam int N_ENTRIES = N_SLOTS / slot_router_pkg::WORD_LANES;
  localparam int ADDR_W    = $clog2(N_ENTRIES);
  localparam int BND_W     = $clog2(N_ENTRIES + 1);

  logic [BND_W-1:0]  bnd_q, bnd_eff;
  logic              lk_keep;
  logic [CH_W-1:0]   lk_chan;
  logic              route_ok;
  logic [CH_W-1:0]   route_ch;
  logic              out_free, take_byte, flushing, flush_take, byte_we;
  logic              word_done;
  logic [31:0]       word_data, flush_data;
  logic [N_CHAN-1:0] pend;
  logic [CH_W-1:0]   flush_ch;
  logic [3:0]        flush_mask;

  logic              ov_q;
  logic [CH_W-1:0]   och_q;
  logic [31:0]       odat_q;
  logic [3:0]        omsk_q;

  assign out_free   = !ov_q || out_ready;
  assign flushing   = in_valid && in_sof && (|pend);
  assign in_ready   = out_free && !(in_sof && (|pend));
  assign take_byte  = in_valid && in_ready;
  assign flush_take = flushing && out_free;
  assign byte_we    = take_byte && route_ok;
  assign bnd_eff    = in_sof ? in_bnd : bnd_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      bnd_q <= '0;
    else if (take_byte && in_sof)
      bnd_q <= in_bnd;
  end

  route_table #(
    .N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .CH_W(CH_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
    .lk_slot(in_slot), .lk_keep(lk_keep), .lk_chan(lk_chan)
  );

  slot_class #(
    .N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .BND_W(BND_W), .CH_W(CH_W)
  ) u_class (
    .slot(in_slot), .bnd(bnd_eff), .tbl_keep(lk_keep), .tbl_chan(lk_chan),
    .route_ok(route_ok), .route_ch(route_ch)
  );

  chan_packer #(.N_CHAN(N_CHAN), .CH_W(CH_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .byte_we(byte_we), .byte_ch(route_ch), .byte_data(in_data),
    .flush_take(flush_take),
    .word_done(word_done), .word_data(word_data),
    .pend(pend), .flush_ch(flush_ch), .flush_data(flush_data),
    .flush_mask(flush_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      och_q  <= '0;
      odat_q <= '0;
      omsk_q <= '0;
    end else if (flush_take) begin
      ov_q   <= 1'b1;
      och_q  <= flush_ch;
      odat_q <= flush_data;
      omsk_q <= flush_mask;
    end else if (word_done) begin
      ov_q   <= 1'b1;
      och_q  <= route_ch;
      odat_q <= word_data;
      omsk_q <= 4'b1111;
    end else if (out_ready) begin
      ov_q   <= 1'b0;
    end
  end

  assign out_valid = ov_q;
  assign out_chan  = och_q;
  assign out_data  = odat_q;
  assign out_bmask = omsk_q;
endmodule

// File: rtl/slot_router_chk.sv
module slot_router_chk #(
  parameter int N_CHAN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_sof,
  input logic              out_valid,
  input logic              out_ready,
  input logic [3:0]        out_chan,
  input logic [31:0]       out_data,
  input logic [3:0]        out_bmask,
  input logic [N_CHAN-1:0] pend
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan) && $stable(out_bmask)); // R9

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_SOF_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof && in_ready |-> pend == '0); // R6

  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bmask == 4'b0001) || (out_bmask == 4'b0011) ||
                  (out_bmask == 4'b0111) || (out_bmask == 4'b1111)); // R6

  AST_PARTIAL_FROM_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_bmask != 4'b1111) && $past(!out_valid || out_ready) |->
      $past(in_valid && in_sof)); // R6

  AST_UNUSED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_bmask[3] |-> out_data[31:24] == 8'h00); // R6
endmodule

bind slot_router slot_router_chk #(.N_CHAN(N_CHAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sof(in_sof), .out_valid(out_valid), .out_ready(out_ready),
  .out_chan(out_chan), .out_data(out_data), .out_bmask(out_bmask),
  .pend(pend)
);

// File: tb/slot_router_bench.sv
module slot_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0;
  logic        in_ready;
  logic [5:0]  in_slot = '0;
  logic [7:0]  in_data = '0;
  logic [3:0]  in_bnd = '0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_addr = '0;
  logic [31:0] tbl_wdata = '0;
  logic        out_valid, out_ready = 1'b1;
  logic [3:0]  out_chan, out_bmask;
  logic [31:0] out_data;

  always #5 clk = ~clk;

  slot_router u_slot_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_slot(in_slot), .in_data(in_data), .in_bnd(in_bnd),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
    .out_data(out_data), .out_bmask(out_bmask)
  );

  int checks = 0, fails = 0, nword = 0, cyc = 0;
  bit stall_en = 1'b0, done = 1'b0;
  string phase = "R1";

  // Behavioural model state
  logic [31:0] tbl_m [15];
  logic [23:0] acc_m [16];
  int          cnt_m [16];
  int          bnd_m = 0;
  logic [31:0] exp_data [$];
  logic [3:0]  exp_ch [$];
  logic [3:0]  exp_msk [$];
  string       exp_tag [$];

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic void push_exp(int ch, logic [31:0] d, logic [3:0] m, string tag);
    exp_ch.push_back(4'(ch));
    exp_data.push_back(d);
    exp_msk.push_back(m);
    exp_tag.push_back(tag);
  endfunction

  function automatic void model_byte(bit sof, int slot, logic [7:0] d);
    int ch;
    logic [7:0] lane;
    if (sof) begin
      bnd_m = int'(in_bnd);                       // R7
      for (int c = 0; c < 16; c++)
        if (cnt_m[c] > 0) begin                   // R6
          push_exp(c, {8'h00, acc_m[c]}, 4'((1 << cnt_m[c]) - 1), {"R6 ", phase});
          cnt_m[c] = 0;
          acc_m[c] = '0;
        end
    end
    if (slot >= 60) return;                       // R4 control slots
    if (slot < 4 * bnd_m) begin
      lane = tbl_m[slot / 4][8 * (slot % 4) +: 8];
      if (!lane[7] || lane[3:0] == 4'h0) return;  // R3
      ch = int'(lane[3:0]);                       // R2
    end else begin
      ch = 0;                                     // R4
    end
    if (cnt_m[ch] == 3) begin                     // R5
      push_exp(ch, {d, acc_m[ch]}, 4'hF, {(ch == 0) ? "R4 " : "R2 R5 ", phase});
      cnt_m[ch] = 0;
      acc_m[ch] = '0;
    end else begin
      acc_m[ch][8 * cnt_m[ch] +: 8] = d;
      cnt_m[ch]++;
    end
  endfunction

  // Drive one byte; optionally a table write in the very cycle the byte is taken (R8)
  task automatic send(bit sof, int slot, logic [7:0] d, bit tw, int ta, logic [31:0] twd);
    model_byte(sof, slot, d);
    if (tw) tbl_m[ta] = twd;
    @(negedge clk);
    in_valid = 1'b1; in_sof = sof; in_slot = 6'(slot); in_data = d;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    if (tw) begin
      tbl_we = 1'b1; tbl_addr = 4'(ta); tbl_wdata = twd;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_sof = 1'b0; tbl_we = 1'b0;
  endtask

  task automatic tbl_write(int a, logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'(a); tbl_wdata = d;
    @(posedge clk);
    #1;
    tbl_we = 1'b0;
    tbl_m[a] = d;
  endtask

  task automatic set_bnd(int b);
    @(negedge clk);
    in_bnd = 4'(b);
  endtask

  task automatic frame(int f, int nslots);
    for (int s = 0; s < nslots; s++)
      send(s == 0, s, 8'((f * 37 + s * 5 + 1) & 255), 1'b0, 0, '0);
  endtask

  // Output throttle and cycle count
  always @(negedge clk) begin
    cyc++;
    out_ready = stall_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor: compared on every clock against the model queue
  logic        prev_stall = 1'b0;
  logic [31:0] held_d;
  logic [3:0]  held_c, held_m;
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (prev_stall)                             // R9 beat held under stall
        check(out_valid && out_data == held_d && out_chan == held_c && out_bmask == held_m,
              "R9", "held beat", {out_chan, out_bmask, out_data}, {held_c, held_m, held_d});
      if (out_valid && !out_ready)
        check(!in_ready, "R9", "in_ready under stall", in_ready, 0);
      prev_stall = out_valid && !out_ready;
      held_d = out_data; held_c = out_chan; held_m = out_bmask;
      if (out_valid && out_ready) begin
        nword++;
        if (exp_data.size() == 0) begin
          check(1'b0, "R5", "unexpected word", out_data, 0);
        end else begin
          string t;
          logic [31:0] ed;
          logic [3:0] ec, em;
          t = exp_tag.pop_front(); ed = exp_data.pop_front();
          ec = exp_ch.pop_front(); em = exp_msk.pop_front();
          check(out_chan == ec, t, $sformatf("word %0d chan", nword), out_chan, ec);
          check(out_data == ed, t, $sformatf("word %0d data", nword), out_data, ed);
          check(out_bmask == em, t, $sformatf("word %0d mask", nword), out_bmask, em);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 15; i++) tbl_m[i] = '0;
    for (int c = 0; c < 16; c++) begin acc_m[c] = '0; cnt_m[c] = 0; end
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "idle after reset",
          {out_valid, in_ready}, 2'b01);

    // R1/R4: boundary zero before the first frame start, all to channel 0
    for (int s = 10; s < 15; s++) send(1'b0, s, 8'(s * 3), 1'b0, 0, '0);

    // R2/R3 table set-up
    tbl_write(0, 32'h0580_8383);   // slot0,1 ch3; slot2 ch0 keep -> discard; slot3 no keep
    tbl_write(1, 32'h8785_8385);   // slot4 ch5, slot5 ch3, slot6 ch5, slot7 ch7
    tbl_write(2, 32'h8F8F_8F8F);   // slots 8-11 ch15
    for (int w = 3; w < 15; w++) tbl_write(w, 32'h8A8A_8A8A);

    phase = "R3";
    set_bnd(2);
    frame(1, 62);

    phase = "R7";                  // boundary change mid-frame waits for next start
    stall_en = 1'b1;
    set_bnd(3);
    for (int s = 0; s < 62; s++) begin
      if (s == 20) set_bnd(15);
      send(s == 0, s, 8'((2 * 37 + s * 5 + 1) & 255), 1'b0, 0, '0);
    end

    phase = "R2";                  // whole data area synchronous
    frame(3, 62);

    phase = "R4";
    set_bnd(0);
    frame(4, 62);

    phase = "R8";                  // write word 0 in the cycle slot 0 is looked up
    set_bnd(1);
    send(1'b1, 0, 8'hA5, 1'b1, 0, 32'h8989_8989);
    for (int s = 1; s < 62; s++) send(1'b0, s, 8'(s + 100), 1'b0, 0, '0);

    phase = "R6";
    stall_en = 1'b0;
    frame(6, 9);
    stall_en = 1'b1;
    send(1'b1, 0, 8'h3C, 1'b0, 0, '0);
    stall_en = 1'b0;

    for (int i = 0; i < 200 && exp_data.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_data.size() == 0, "R5", "words left undelivered", exp_data.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule